// File: doc/BRIEF.md
# Audio DMA Byte Sequencer

This block sits between an audio sample FIFO and an 8-bit DMA handshake of the ISA style. For playback it raises a request, and on each acknowledged bus write it takes one byte. It assembles the bytes into a 32-bit frame word and pushes that word into the playback FIFO once the frame is complete. For capture it raises a request while the capture FIFO holds a frame. On each acknowledged bus read it drives one byte of the head frame, and after the last byte of that frame it pops the FIFO. Samples can be mono or stereo and 8 or 16 bits wide. The bytes of a frame always follow a fixed order: the left channel before the right, and within a 16-bit sample the low byte before the high byte.

Each direction has its own sample counter. Both counters reload from one 16-bit base value, which the host writes as two byte registers. Each time a counter runs out, the block sets an interrupt-pending flag for its direction. The host port also holds the enable and format bits. Playback always uses request/acknowledge pair A. Capture uses pair B in dual-channel operation, and pair A in single-channel operation.

Top module: `dma_byte_sequencer`

## Requirements
- R1: After reset both request outputs are low, `pb_push` and `cap_pop` are low, and all four host registers read as zero.
- R2: Host register 2 holds the low byte and register 3 the high byte of the 16-bit base count. A read of either returns the last value written to it.
- R3: Control register 0 holds these bits: bit0 playback enable, bit1 capture enable, bit2 stereo, bit3 16-bit samples, bit4 dual-channel. A frame word is {right[15:0], left[15:0]}. A 16-bit stereo frame takes its four bytes in the order left-low, left-high, right-low, right-high, which fill word bytes 0, 1, 2 and 3.
- R4: A 16-bit mono frame takes two bytes, low then high, into word bits [15:0]. An 8-bit stereo frame takes two bytes, left then right, into word bits [7:0] and [23:16]. An 8-bit mono frame takes one byte into bits [7:0]. Every bit of the pushed word that no byte fills is zero.
- R5: Capture drives the bytes of the head frame on `bus_rdata` in the same order and from the same word positions as R3/R4. It pulses `cap_pop` for one cycle after the last byte of the frame.
- R6: With base value B, the pending flag of a direction is set on the completion of frame B+1 after that direction is enabled. The counter then reloads, so the next setting comes after a further B+1 frames.
- R7: Status register 1 shows the playback pending flag at bit0 and the capture pending flag at bit1. A flag stays set until the host writes 1 to its bit. A write of 0 leaves it unchanged.
- R8: The playback request is low while playback is disabled or `pb_full` is high. The capture request is low while capture is disabled or `cap_empty` is high.
- R9: A bus strobe is ignored when its acknowledge is low, and also when its direction is disabled. An ignored strobe does not advance the byte order and does not push.
- R10: With dual-channel set, capture requests on `drq_b` and uses `dack_b`. With it clear, capture uses `drq_a`/`dack_a`, but only while playback is disabled, and `drq_b` stays low.
- R11: A byte is taken on the trailing (falling) edge of the active-high strobe. The push or pop that results appears in the cycle after that edge, never while the strobe is still high.
- R12: `pb_push` and `cap_pop` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Host register select |
| reg_wr | input | 1 | Host register write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data of the selected register |
| drq_a | output | 1 | Request, pair A |
| drq_b | output | 1 | Request, pair B |
| dack_a | input | 1 | Acknowledge, pair A |
| dack_b | input | 1 | Acknowledge, pair B |
| bus_wr | input | 1 | Active-high bus write strobe (playback byte) |
| bus_rd | input | 1 | Active-high bus read strobe (capture byte) |
| bus_wdata | input | 8 | Playback byte from the bus |
| bus_rdata | output | 8 | Capture byte to the bus, zero outside an acknowledged read |
| pb_full | input | 1 | Playback FIFO full |
| pb_push | output | 1 | Playback frame push pulse |
| pb_word | output | 32 | Playback frame word |
| cap_empty | input | 1 | Capture FIFO empty |
| cap_word | input | 32 | Capture FIFO head frame |
| cap_pop | output | 1 | Capture frame pop pulse |

## Verification
The assertions assume that the acknowledge of a pair stays high for the whole strobe and for the cycle in which the strobe falls. They also assume that strobes are separated by at least one low cycle, and that the format bits change only while a direction is disabled. The bench drives every bus cycle through one write task and one read task, which keep acknowledge high from before the strobe rises until after it falls. It reprograms the format only with both enables cleared. Its FIFO models advance only on the pulses they observe.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    // Host register selects
    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_STAT    = 2'd1,
        SEL_BASE_LO = 2'd2,
        SEL_BASE_HI = 2'd3
    } reg_sel_e;

    // Control bits, bit0 first from the right
    typedef struct packed {
        logic dual;
        logic wide;
        logic stereo;
        logic cap_en;
        logic play_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Index of the last byte in a frame for a given format
    function automatic logic [1:0] last_phase(input logic stereo, input logic wide);
        return {stereo & wide, stereo | wide};
    endfunction

    // Byte lane of the frame word for a byte position within the frame
    function automatic logic [1:0] lane_of(input logic [1:0] phase, input logic wide);
        return wide ? phase : {phase[0], 1'b0};
    endfunction

endpackage

// File: rtl/dma_strobe_edge.sv
// Trailing-edge detector for an active-high bus strobe.
// Assumes the acknowledge is held through the strobe; the event fires in the
// cycle the strobe is first seen low, qualified by acknowledge seen while high.
module dma_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strb,
    input  logic ack,
    output logic evt
);
    logic strb_q;
    logic act_q;

    // Remember strobe level and whether it was acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q <= 1'b0;
            act_q  <= 1'b0;
        end else begin
            strb_q <= strb;
            act_q  <= strb & ack;
        end
    end

    assign evt = strb_q & ~strb & act_q;
endmodule

// File: rtl/dma_frame_track.sv
// Per-direction byte position and sample counter.
// Assumes format bits are stable while enabled. While disabled the position is
// cleared and the counter preloaded from base; each completed frame counts one
// sample, and the frame that finds the counter at zero expires and reloads it.
module dma_frame_track
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stereo,
    input  logic             wide,
    input  logic             byte_evt,
    input  logic [CNT_W-1:0] base,
    output logic             take,
    output logic             first,
    output logic [1:0]       lane,
    output logic             frame_done,
    output logic             expire
);
    logic [1:0]       phase_q;
    logic [CNT_W-1:0] cnt_q;

    assign take       = en & byte_evt;
    assign first      = (phase_q == 2'd0);
    assign lane       = lane_of(phase_q, wide);
    assign frame_done = take & (phase_q == last_phase(stereo, wide));
    assign expire     = frame_done & (cnt_q == '0);

    // Advance the byte position and the sample counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 2'd0;
            cnt_q   <= '0;
        end else if (!en) begin
            phase_q <= 2'd0;
            cnt_q   <= base;
        end else if (take) begin
            phase_q <= frame_done ? 2'd0 : phase_q + 2'd1;
            if (frame_done)
                cnt_q <= (cnt_q == '0) ? base : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dma_host_regs.sv
// Host register file: control, sticky pending flags, split base count.
// Assumes one access per cycle; a pending set wins over a clear in the same cycle.
module dma_host_regs
    import dma_seq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [1:0]        expire,
    output ctrl_t             ctrl,
    output logic [2*BYTE_W-1:0] base,
    output logic [1:0]        pend
);
    logic [BYTE_W-1:0] base_lo_q;
    logic [BYTE_W-1:0] base_hi_q;
    logic [1:0]        clr;
    reg_sel_e          sel_e;

    assign sel_e = reg_sel_e'(sel);
    assign base  = {base_hi_q, base_lo_q};
    assign clr   = (wr && sel_e == SEL_STAT) ? wdata[1:0] : 2'b00;

    // Register writes and pending flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            base_lo_q <= '0;
            base_hi_q <= '0;
            pend      <= 2'b00;
        end else begin
            pend <= (pend & ~clr) | expire;
            if (wr) begin
                case (sel_e)
                    SEL_CTRL:    ctrl      <= ctrl_t'(wdata[CTRL_W-1:0]);
                    SEL_BASE_LO: base_lo_q <= wdata;
                    SEL_BASE_HI: base_hi_q <= wdata;
                    default:     ;
                endcase
            end
        end
    end

    // Read mux of the selected register
    always_comb begin
        case (sel_e)
            SEL_CTRL:    rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl};
            SEL_STAT:    rdata = {{(BYTE_W-2){1'b0}}, pend};
            SEL_BASE_LO: rdata = base_lo_q;
            default:     rdata = base_hi_q;
        endcase
    end
endmodule

// File: rtl/dma_byte_sequencer.sv
// Audio DMA byte sequencer top.
// Assumes acknowledges are held across their strobes and format changes only
// while a direction is disabled. Playback assembles bytes into a frame word and
// pushes it; capture serves bytes of the head frame and pops it.
module dma_byte_sequencer
    import dma_seq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          reg_sel,
    input  logic                reg_wr,
    input  logic [BYTE_W-1:0]   reg_wdata,
    output logic [BYTE_W-1:0]   reg_rdata,
    output logic                drq_a,
    output logic                drq_b,
    input  logic                dack_a,
    input  logic                dack_b,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic                pb_full,
    output logic                pb_push,
    output logic [4*BYTE_W-1:0] pb_word,
    input  logic                cap_empty,
    input  logic [4*BYTE_W-1:0] cap_word,
    output logic                cap_pop
);
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int FRAME_W = 4 * BYTE_W;
    localparam int N_DIR   = 2;   // 0 playback, 1 capture

    ctrl_t             ctrl;
    logic [CNT_W-1:0]  base;
    logic [1:0]        pend;
    logic              play_req, cap_req, cap_on_a;
    logic              play_ack, cap_ack;
    logic              wr_hit, rd_hit;
    logic [BYTE_W-1:0] wr_byte;
    logic [FRAME_W-1:0] asm_q, asm_next;

    logic [N_DIR-1:0]  dir_en, dir_evt, dir_take, dir_first, dir_done, dir_expire;
    logic [1:0]        dir_lane [N_DIR];

    // Request and acknowledge routing
    assign play_req = ctrl.play_en & ~pb_full;
    assign cap_req  = ctrl.cap_en & ~cap_empty;
    assign cap_on_a = ~ctrl.dual & ~ctrl.play_en;
    assign drq_a    = play_req | (cap_req & cap_on_a);
    assign drq_b    = cap_req & ctrl.dual;
    assign play_ack = dack_a & ctrl.play_en;
    assign cap_ack  = ctrl.cap_en & (ctrl.dual ? dack_b : (dack_a & cap_on_a));

    dma_host_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (reg_sel),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .expire (dir_expire),
        .ctrl   (ctrl),
        .base   (base),
        .pend   (pend)
    );

    dma_strobe_edge u_wr_edge (
        .clk (clk), .rst_n (rst_n), .strb (bus_wr), .ack (play_ack), .evt (wr_hit)
    );

    dma_strobe_edge u_rd_edge (
        .clk (clk), .rst_n (rst_n), .strb (bus_rd), .ack (cap_ack), .evt (rd_hit)
    );

    assign dir_en  = {ctrl.cap_en, ctrl.play_en};
    assign dir_evt = {rd_hit, wr_hit};

    // One byte-position tracker and sample counter per direction
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        dma_frame_track #(.CNT_W(CNT_W)) u_track (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (dir_en[d]),
            .stereo     (ctrl.stereo),
            .wide       (ctrl.wide),
            .byte_evt   (dir_evt[d]),
            .base       (base),
            .take       (dir_take[d]),
            .first      (dir_first[d]),
            .lane       (dir_lane[d]),
            .frame_done (dir_done[d]),
            .expire     (dir_expire[d])
        );
    end

    // Hold the playback byte while the strobe is high
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_byte <= '0;
        else if (bus_wr) wr_byte <= bus_wdata;
    end

    // Place the incoming byte into its lane; a new frame starts from zero
    always_comb begin
        asm_next = dir_first[0] ? '0 : asm_q;
        asm_next[dir_lane[0]*BYTE_W +: BYTE_W] = wr_byte;
    end

    // Frame assembly, push and pop pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q   <= '0;
            pb_word <= '0;
            pb_push <= 1'b0;
            cap_pop <= 1'b0;
        end else begin
            pb_push <= dir_done[0];
            cap_pop <= dir_done[1];
            if (dir_take[0]) asm_q   <= asm_next;
            if (dir_done[0]) pb_word <= asm_next;
        end
    end

    // Capture byte of the head frame during an acknowledged read
    assign bus_rdata = (bus_rd & cap_ack) ? cap_word[dir_lane[1]*BYTE_W +: BYTE_W] : '0;

endmodule

// File: rtl/dma_byte_sequencer_chk.sv
// Property checker for the byte sequencer, bound to the top module.
module dma_byte_sequencer_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              drq_a,
    input logic              drq_b,
    input logic              pb_full,
    input logic              cap_empty,
    input logic [4:0]        ctrl_bits,
    input logic              pb_push,
    input logic              cap_pop,
    input logic [1:0]        pend,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic [2*BYTE_W-1:0] base,
    input logic              bus_wr,
    input logic              bus_rd
);
    // R8: playback request never stands against a full FIFO
    a_r8_play_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (drq_a && ctrl_bits[0]) |-> !pb_full);

    // R8: capture request on pair B needs capture enabled and data present
    a_r8_cap_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        drq_b |-> (ctrl_bits[1] && !cap_empty));

    // R10: pair B only in dual-channel operation
    a_r10_b_needs_dual: assert property (@(posedge clk) disable iff (!rst_n)
        drq_b |-> ctrl_bits[4]);

    // R12: single-cycle pulses
    a_r12_push_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pb_push |=> !pb_push);
    a_r12_pop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pop |=> !cap_pop);

    // R11: push or pop only after the strobe has fallen
    a_r11_push_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        pb_push |-> !$past(bus_wr));
    a_r11_pop_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pop |-> !$past(bus_rd));

    // R9: no push unless playback was enabled
    a_r9_push_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        pb_push |-> $past(ctrl_bits[0]));

    // R7: pending flags clear only by a host write of 1
    a_r7_play_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend[0]) |-> $past(reg_wr && reg_sel == 2'd1 && reg_wdata[0]));
    a_r7_cap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend[1]) |-> $past(reg_wr && reg_sel == 2'd1 && reg_wdata[1]));

    // R2: base bytes take the written value
    a_r2_base_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd2) |=> base[BYTE_W-1:0] == $past(reg_wdata));
    a_r2_base_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd3) |=> base[2*BYTE_W-1:BYTE_W] == $past(reg_wdata));
endmodule

bind dma_byte_sequencer dma_byte_sequencer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drq_a     (drq_a),
    .drq_b     (drq_b),
    .pb_full   (pb_full),
    .cap_empty (cap_empty),
    .ctrl_bits (ctrl),
    .pb_push   (pb_push),
    .cap_pop   (cap_pop),
    .pend      (pend),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .base      (base),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd)
);

// File: tb/dma_byte_sequencer_test.sv
module dma_byte_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        drq_a, drq_b;
    logic        dack_a = 1'b0, dack_b = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        pb_full = 1'b0;
    logic        pb_push;
    logic [31:0] pb_word;
    logic        cap_empty;
    logic [31:0] cap_word;
    logic        cap_pop;

    logic [31:0] cap_mem [16];
    int          cap_idx = 0;
    int          cap_cnt = 0;
    logic [31:0] push_log [$];
    int          n_checks = 0;
    int          n_fail = 0;
    int          cycles = 0;
    bit          done = 0;

    assign cap_empty = (cap_idx >= cap_cnt);
    assign cap_word  = cap_mem[cap_idx[3:0]];

    always #2 clk = ~clk;   // 250 MHz

    dma_byte_sequencer uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drq_a(drq_a), .drq_b(drq_b),
        .dack_a(dack_a), .dack_b(dack_b), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pb_full(pb_full),
        .pb_push(pb_push), .pb_word(pb_word), .cap_empty(cap_empty),
        .cap_word(cap_word), .cap_pop(cap_pop)
    );

    // FIFO models observe pulses away from the active edge
    always @(negedge clk) begin
        if (pb_push) push_log.push_back(pb_word);
        if (cap_pop) cap_idx <= cap_idx + 1;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [7:0] data);
        @(negedge clk);
        reg_sel = sel;
        #1 data = reg_rdata;
    endtask

    // One playback bus byte; ack selects whether dack_a is asserted
    task automatic dma_write(input logic [7:0] b, input bit ack);
        @(negedge clk);
        bus_wdata = b; bus_wr = 1'b1; dack_a = ack;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        dack_a = 1'b0;
        @(negedge clk);
    endtask

    // One capture bus byte on pair B (use_b) or pair A
    task automatic dma_read(input bit use_b, output logic [7:0] b);
        @(negedge clk);
        bus_rd = 1'b1;
        if (use_b) dack_b = 1'b1; else dack_a = 1'b1;
        @(negedge clk);
        b = bus_rdata;
        bus_rd = 1'b0;
        @(negedge clk);
        dack_a = 1'b0; dack_b = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] pack(bit st, bit wd, logic [7:0] b0, logic [7:0] b1,
                                         logic [7:0] b2, logic [7:0] b3);
        if (st && wd)  return {b3, b2, b1, b0};
        if (wd)        return {16'h0, b1, b0};
        if (st)        return {8'h0, b1, 8'h0, b0};
        return {24'h0, b0};
    endfunction

    function automatic logic [7:0] pick(bit st, bit wd, logic [31:0] w, int k);
        if (st && wd) return w[k*8 +: 8];
        if (wd)       return w[k*8 +: 8];
        if (st)       return (k == 0) ? w[7:0] : w[23:16];
        return w[7:0];
    endfunction

    task automatic configure(input logic [7:0] ctrl_val, input logic [15:0] base_val);
        reg_write(2'd0, 8'h00);
        reg_write(2'd1, 8'h03);
        reg_write(2'd2, base_val[7:0]);
        reg_write(2'd3, base_val[15:8]);
        reg_write(2'd0, ctrl_val);
    endtask

    task automatic test_reset();
        logic [7:0] r;
        chk("R1 drq_a", {31'd0, drq_a}, 32'd0);
        chk("R1 drq_b", {31'd0, drq_b}, 32'd0);
        chk("R1 pulses", {30'd0, pb_push, cap_pop}, 32'd0);
        for (int s = 0; s < 4; s++) begin
            reg_read(2'(s), r);
            chk("R1 register", {24'd0, r}, 32'd0);
        end
    endtask

    task automatic test_base_readback();
        logic [7:0] r;
        reg_write(2'd2, 8'hA5);
        reg_write(2'd3, 8'h3C);
        reg_read(2'd2, r); chk("R2 base low", {24'd0, r}, 32'hA5);
        reg_read(2'd3, r); chk("R2 base high", {24'd0, r}, 32'h3C);
    endtask

    // Byte order and interrupt spacing for playback in one format (R3 R4 R6 R7)
    task automatic test_play(input bit st, input bit wd);
        int n = (st ? 2 : 1) * (wd ? 2 : 1);
        logic [7:0] b [4];
        logic [7:0] r;
        configure({4'b0, wd, st, 2'b01}, 16'd2);
        push_log.delete();
        for (int rnd = 0; rnd < 2; rnd++) begin
            for (int f = 0; f < 3; f++) begin
                for (int k = 0; k < 4; k++) b[k] = 8'(rnd * 100 + f * 10 + k + 1 + (st ? 40 : 0) + (wd ? 20 : 0));
                for (int k = 0; k < n; k++) begin
                    if (f == 2 && k == n - 1) begin
                        reg_read(2'd1, r);
                        chk("R6 no early play interrupt", {24'd0, r}, 32'd0);
                    end
                    dma_write(b[k], 1'b1);
                end
                @(negedge clk);
                chk("R3 R4 push count", push_log.size(), 32'd1);
                if (push_log.size() > 0)
                    chk(st && wd ? "R3 frame word" : "R4 frame word", push_log.pop_front(),
                        pack(st, wd, b[0], b[1], b[2], b[3]));
                push_log.delete();
            end
            reg_read(2'd1, r);
            chk("R6 play interrupt after base+1 frames", {24'd0, r}, 32'd1);
            reg_write(2'd1, 8'h00);
            reg_read(2'd1, r);
            chk("R7 write 0 keeps flag", {24'd0, r}, 32'd1);
            reg_write(2'd1, 8'h01);
            reg_read(2'd1, r);
            chk("R7 write 1 clears flag", {24'd0, r}, 32'd0);
        end
    endtask

    // Capture byte order, pop and interrupt (R5 R6 R10)
    task automatic test_cap(input bit st, input bit wd);
        int n = (st ? 2 : 1) * (wd ? 2 : 1);
        logic [7:0] got;
        logic [7:0] r;
        reg_write(2'd0, 8'h00);
        for (int i = 0; i < 3; i++) cap_mem[i] = 32'h11223344 + 32'(i) * 32'h01010101 + (st ? 32'h40 : 0);
        cap_idx = 0; cap_cnt = 3;
        configure({3'b0, 1'b1, wd, st, 2'b10}, 16'd2);
        #1 chk("R10 capture on pair B in dual", {30'd0, drq_a, drq_b}, 32'd1);
        for (int f = 0; f < 3; f++) begin
            for (int k = 0; k < n; k++) begin
                dma_read(1'b1, got);
                chk("R5 capture byte", {24'd0, got}, {24'd0, pick(st, wd, cap_mem[f], k)});
            end
            @(negedge clk);
            chk("R5 pop after last byte", cap_idx, f + 1);
            if (f == 1) begin
                reg_read(2'd1, r);
                chk("R6 no early capture interrupt", {24'd0, r}, 32'd0);
            end
        end
        reg_read(2'd1, r);
        chk("R6 capture interrupt", {24'd0, r}, 32'd2);
        reg_write(2'd1, 8'h02);
    endtask

    task automatic test_gating();
        configure(8'h01, 16'd0);
        pb_full = 1'b1;
        #1 chk("R8 full blocks request", {31'd0, drq_a}, 32'd0);
        pb_full = 1'b0;
        #1 chk("R8 request when room", {31'd0, drq_a}, 32'd1);
        reg_write(2'd0, 8'h00);
        #1 chk("R8 disabled no request", {31'd0, drq_a}, 32'd0);
        cap_idx = 0; cap_cnt = 0;
        reg_write(2'd0, 8'h12);
        #1 chk("R8 empty blocks capture request", {31'd0, drq_b}, 32'd0);
    endtask

    task automatic test_ignore();
        push_log.delete();
        configure(8'h09, 16'd5);               // playback, 16-bit mono
        dma_write(8'hEE, 1'b0);                // no acknowledge
        dma_write(8'h21, 1'b1);
        dma_write(8'h43, 1'b1);
        @(negedge clk);
        chk("R9 unacknowledged byte ignored", push_log.size(), 32'd1);
        if (push_log.size() > 0) chk("R9 word after ignored byte", push_log.pop_front(), 32'h00004321);
        reg_write(2'd0, 8'h08);                // playback disabled
        dma_write(8'h77, 1'b1);
        dma_write(8'h78, 1'b1);
        @(negedge clk);
        chk("R9 disabled no push", push_log.size(), 32'd0);
    endtask

    task automatic test_single();
        logic [7:0] got;
        reg_write(2'd0, 8'h00);
        cap_mem[0] = 32'hCAFE0055; cap_idx = 0; cap_cnt = 1;
        configure(8'h02, 16'd0);               // capture, single channel, 8-bit mono
        #1 chk("R10 single uses pair A", {30'd0, drq_a, drq_b}, 32'd2);
        dma_read(1'b0, got);
        chk("R10 byte on pair A", {24'd0, got}, 32'h55);
        @(negedge clk);
        chk("R10 pop on pair A", cap_idx, 32'd1);
        cap_idx = 0;
        reg_write(2'd0, 8'h03);                // playback also on: A belongs to playback
        #1 chk("R10 pair B idle in single", {31'd0, drq_b}, 32'd0);
    endtask

    task automatic test_edge();
        configure(8'h01, 16'd0);               // playback, 8-bit mono
        push_log.delete();
        @(negedge clk);
        bus_wdata = 8'h9A; bus_wr = 1'b1; dack_a = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 no push while strobe high", {31'd0, pb_push}, 32'd0);
        bus_wr = 1'b0;
        @(negedge clk);
        chk("R11 push after falling edge", {31'd0, pb_push}, 32'd1);
        chk("R11 word", pb_word, 32'h0000009A);
        @(negedge clk);
        dack_a = 1'b0;
        chk("R12 push is one cycle", {31'd0, pb_push}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_base_readback();
        for (int m = 0; m < 4; m++) test_play(m[1], m[0]);
        for (int m = 0; m < 4; m++) test_cap(m[1], m[0]);
        test_gating();
        test_ignore();
        test_single();
        test_edge();
        if (!done) begin
            done = 1;
            summary();
            $finish;
        end
    end
endmodule